// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Conditioner

This block turns one asynchronous external pin into a clean interrupt event for a small core. The pin first passes through a multi-flop synchroniser. A programmable edge detector then looks for a rising or a falling transition, depending on a polarity control bit. A detected edge sets a sticky flag, and only a software clear strobe resets that flag. An enable bit decides whether the flag is passed on to the core as an interrupt request. The flag records edges whatever the enable bit holds.

A pin can be set up as an analog input. In that case its digital reading is forced to 0, and it can produce neither an edge nor an interrupt. The edge detector is re-armed for one cycle whenever the polarity bit or the analog-select bit changes, so a configuration write cannot fake an edge. While the core sleeps, a valid edge raises a wake request, but only if the enable bit was already set when sleep began. The wake request then stays high until the core leaves sleep.

Top module: `ext_irq_cond`

## Requirements
- R1: With the polarity bit at 1, a 0-to-1 transition on the pin sets the flag, and it is visible on `flag_o` three clock cycles after the pin changes. A 1-to-0 transition does not set the flag.
- R2: With the polarity bit at 0, a 1-to-0 transition on the pin sets the flag three cycles after the pin changes. A 0-to-1 transition does not set the flag.
- R3: The flag stays set until `flag_clr_i` is sampled high at a clock edge. It reads 0 from the cycle after that edge, unless R7 applies.
- R4: `irq_o` equals the flag ANDed with `irq_en_i` and is updated on the same edge as the flag. While `irq_en_i` is 0, edges still set the flag.
- R5: While `analog_sel_i` is 1, `pin_dig_o` reads 0, and no pin transition sets the flag or raises a wake request.
- R6: A change of `pol_rise_i` or `analog_sel_i` alone never sets the flag. This includes switching a high pin between digital and analog, which changes the level the detector sees.
- R7: If an edge is detected in the same cycle that the clear strobe is sampled, the flag remains set.
- R8: While `sleep_i` is 1, a valid edge raises `wake_o` on the same edge as the flag, provided `irq_en_i` was 1 on the cycle sleep began and is still 1. Setting the enable bit later in the sleep does not allow a wake. `wake_o` holds until `sleep_i` returns to 0 and drops on the next clock edge after that.
- R9: With the pin digital, `pin_dig_o` follows the pin level three cycles late.
- R10: While `rst` is high, and on the first cycle after it, `flag_o`, `irq_o`, `wake_o` and `pin_dig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous external pin |
| pol_rise_i | input | 1 | 1: rising edge triggers, 0: falling edge triggers |
| analog_sel_i | input | 1 | 1: pin is analog, so its digital value is masked to 0 |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| sleep_i | input | 1 | Core sleep status |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up request to a sleeping core |
| pin_dig_o | output | 1 | Synchronised, masked digital pin value |

## Verification
A pin change driven at a falling clock edge passes two synchroniser flops. The edge register and the output registers then capture it, so `flag_o`, `irq_o`, `wake_o` and `pin_dig_o` move on the third rising edge. The bench samples them at the third falling edge after the stimulus. A clear strobe or a sleep exit is seen at the very next rising edge, and the bench checks its result one cycle later. The R7 collision is produced by raising the clear strobe exactly two cycles after the pin changes, so that the clear and the detected edge meet on the same rising edge. Every combination of polarity, analog select and enable is swept, and the expected flag and request values are computed in the bench from those three bits.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic analog_i,
  output logic level_o
);
  import ext_irq_pkg::*;

  localparam int unsigned DEPTH = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], pin_i};
  end

  // analog pins read as zero for the detector
  assign level_o = analog_i ? 1'b0 : chain_q[DEPTH-1];

  AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    analog_i |-> !level_o); // R5
endmodule

// File: rtl/eic_edge.sv
module eic_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic pol_i,
  input  logic analog_i,
  output logic edge_o,
  output logic level_q_o
);
  import ext_irq_pkg::*;

  edge_pol_e pol_e;
  logic      prev_q;
  logic      pol_q;
  logic      ana_q;
  logic      cfg_chg;
  logic      rise;
  logic      fall;

  assign pol_e = edge_pol_e'(pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pol_q  <= 1'b0;
      ana_q  <= 1'b0;
    end else begin
      prev_q <= level_i;
      pol_q  <= pol_i;
      ana_q  <= analog_i;
    end
  end

  assign cfg_chg = (pol_i != pol_q) || (analog_i != ana_q);
  assign rise    = level_i && !prev_q;
  assign fall    = !level_i && prev_q;

  always_comb begin
    edge_o = 1'b0;
    if (!cfg_chg) begin
      unique case (pol_e)
        EDGE_RISE: edge_o = rise;
        EDGE_FALL: edge_o = fall;
        default:   edge_o = 1'b0;
      endcase
    end
  end

  assign level_q_o = prev_q;

  AST_ANALOG_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    analog_i |-> !edge_o); // R5
  AST_WRONG_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (edge_o && pol_i) |-> level_i); // R1
endmodule

// File: rtl/eic_flag.sv
module eic_flag (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic sleep_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);
  logic flag_q;
  logic flag_nxt;
  logic irq_q;
  logic wake_q;
  logic sleep_q;
  logic slp_en_q;
  logic en_ok;

  // a set from an edge wins over the software clear
  assign flag_nxt = edge_i || (flag_q && !clr_i);

  // enable as it stood on the cycle sleep began
  assign en_ok = sleep_q ? slp_en_q : en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      wake_q   <= 1'b0;
      sleep_q  <= 1'b0;
      slp_en_q <= 1'b0;
    end else begin
      flag_q   <= flag_nxt;
      irq_q    <= flag_nxt && en_i;
      sleep_q  <= sleep_i;
      slp_en_q <= sleep_i ? en_ok : 1'b0;
      wake_q   <= sleep_i && (wake_q || (edge_i && en_ok && en_i));
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o); // R3
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (edge_i && clr_i) |=> flag_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o); // R4
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> !wake_o); // R8
  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> flag_o); // R8
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_rise_i,
  input  logic analog_sel_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  input  logic sleep_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o,
  output logic pin_dig_o
);
  logic level;
  logic edge_det;

  eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (pin_i),
    .analog_i (analog_sel_i),
    .level_o  (level)
  );

  eic_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .level_i   (level),
    .pol_i     (pol_rise_i),
    .analog_i  (analog_sel_i),
    .edge_o    (edge_det),
    .level_q_o (pin_dig_o)
  );

  eic_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .edge_i  (edge_det),
    .clr_i   (flag_clr_i),
    .en_i    (irq_en_i),
    .sleep_i (sleep_i),
    .flag_o  (flag_o),
    .irq_o   (irq_o),
    .wake_o  (wake_o)
  );

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o); // R4
  AST_CFG_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && (pol_rise_i != $past(pol_rise_i) || analog_sel_i != $past(analog_sel_i))
     && !$past(rst)) |=> !flag_o); // R6
endmodule

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;
  logic clk = 1'b0;
  logic rst;
  logic pin, pol, ana, en, clr, slp;
  logic flag, irq, wake, pdig;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_cond u_ext_irq_cond (
    .clk          (clk),
    .rst          (rst),
    .pin_i        (pin),
    .pol_rise_i   (pol),
    .analog_sel_i (ana),
    .irq_en_i     (en),
    .flag_clr_i   (clr),
    .sleep_i      (slp),
    .flag_o       (flag),
    .irq_o        (irq),
    .wake_o       (wake),
    .pin_dig_o    (pdig)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(1);
  endtask

  initial begin
    rst = 1'b1; pin = 1'b0; pol = 1'b1; ana = 1'b0; en = 1'b0; clr = 1'b0; slp = 1'b0;
    step(3);
    chk("R10 flag in reset", flag, 0);
    chk("R10 irq in reset", irq, 0);
    chk("R10 wake in reset", wake, 0);
    rst = 1'b0;
    step(1);
    chk("R10 pin_dig after reset", pdig, 0);
    chk("R10 flag after reset", flag, 0);

    // sweep polarity x analog x enable
    for (int c = 0; c < 8; c++) begin
      pol = c[0]; ana = c[1]; en = c[2];
      pin = 1'b0;
      step(4);
      clear_flag();
      chk("R3 cleared before sweep", flag, 0);
      pin = 1'b1;
      step(3);
      chk(c[0] ? "R1 rise sets" : "R2 rise ignored", flag, int'(!ana && pol));
      chk("R4 irq follows flag and enable", irq, int'(!ana && pol && en));
      chk(ana ? "R5 analog reads zero" : "R9 pin_dig high", pdig, int'(!ana));
      step(5);
      chk("R3 flag holds without clear", flag, int'(!ana && pol));
      clear_flag();
      chk("R3 clear strobe", flag, 0);
      pin = 1'b0;
      step(3);
      chk(c[0] ? "R1 fall ignored" : "R2 fall sets", flag, int'(!ana && !pol));
      chk("R4 irq follows flag and enable", irq, int'(!ana && !pol && en));
      chk("R9 pin_dig low", pdig, 0);
    end

    // R6: config changes with the pin held high
    pol = 1'b0; ana = 1'b0; en = 1'b1; pin = 1'b1;
    step(5);
    clear_flag();
    ana = 1'b1;
    step(4);
    chk("R6 analog switch on high pin (falling mode)", flag, 0);
    pol = 1'b1;
    step(2);
    ana = 1'b0;
    step(4);
    chk("R6 analog switch off high pin (rising mode)", flag, 0);
    pol = 1'b0;
    step(3);
    pol = 1'b1;
    step(3);
    chk("R6 polarity toggles", flag, 0);

    // R7: edge meets clear on the same clock edge
    pol = 1'b1; ana = 1'b0; pin = 1'b0;
    step(4);
    pin = 1'b1;
    step(4);
    chk("R7 flag set first", flag, 1);
    pin = 1'b0;
    step(4);
    pin = 1'b1;
    step(2);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk("R7 edge beats clear", flag, 1);
    clear_flag();
    chk("R7 control clear", flag, 0);

    // R8: wake with enable set before sleep
    pin = 1'b0; en = 1'b1;
    step(4);
    clear_flag();
    slp = 1'b1;
    step(2);
    chk("R8 no wake without edge", wake, 0);
    pin = 1'b1;
    step(3);
    chk("R8 wake on edge", wake, 1);
    step(3);
    chk("R8 wake holds", wake, 1);
    slp = 1'b0;
    step(1);
    chk("R8 wake drops after sleep exit", wake, 0);

    // R8: enable set only after sleep began
    pin = 1'b0; en = 1'b0;
    step(4);
    clear_flag();
    slp = 1'b1;
    step(2);
    en = 1'b1;
    step(2);
    pin = 1'b1;
    step(3);
    chk("R8 late enable gives no wake", wake, 0);
    chk("R8 flag still records", flag, 1);
    slp = 1'b0;
    step(1);

    // R5: analog pin during sleep
    pin = 1'b0; ana = 1'b1;
    step(4);
    clear_flag();
    slp = 1'b1;
    step(2);
    pin = 1'b1;
    step(4);
    chk("R5 analog no wake", wake, 0);
    chk("R5 analog no flag", flag, 0);
    slp = 1'b0;
    step(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule